// File: doc/BRIEF.md
# Peripheral Slot Select Decoder

This block turns a four-bit field of a physical address into one of sixteen active-low select lines that feed the expansion connectors. The field is taken from address bits 24 down to 21. Only some codes are populated slots. Code 0 is decoded internally but drives nothing, codes 13 to 15 are reserved, and a parameter sets how many slots are fitted. Whenever a populated slot is addressed while the qualifying address strobe is low, the block raises one composite active-low request. That request goes to an external memory arbiter and asks it for a bypass path to the connectors.

The arbiter answers with an active-low bypass acknowledge. The selected line is driven onto the connector outputs only while that acknowledge is low. The acknowledge also controls the address capture stage. While the acknowledge is high the stage follows the incoming address on every clock. While it is low the stage holds, so the decoded slot cannot change during a granted transfer. If a new strobe begins while the previous grant is still held, the block locks itself out. It raises no request until the arbiter has released the acknowledge.

Top module: `slot_select_decoder`

## Requirements
- R1: The captured field value k (address bits 24..21) selects line k alone: during a grant exactly slot_sel_n_o[k] is low and all other lines are high.
- R2: Every select, request and acknowledge is active low. One clock edge with rst high leaves byp_req_n_o high and all of slot_sel_n_o high.
- R3: Code 0 never pulls any select low and never raises the request.
- R4: Codes 13, 14 and 15 are reserved. They never pull a select low and never raise the request.
- R5: The parameter POPULATED (12 by default, 4 in the small build) limits the live codes to 1..POPULATED. Any higher code gives no select and no request.
- R6: With as_n_i low, byp_ack_n_i high and a live code held on paddr_i, byp_req_n_o is low by the second rising edge. With as_n_i high it stays high.
- R7: slot_sel_n_o lines are low only while byp_ack_n_i is low. When the acknowledge is high, all lines are high in the same cycle.
- R8: The captured address follows paddr_i on each edge at which byp_ack_n_i is high and holds while it is low. A change on paddr_i during a grant does not change the selected line.
- R9: byp_req_n_o goes high at the first rising edge after as_n_i has gone high.
- R10: A falling edge of as_n_i seen while byp_ack_n_i is low keeps the request high and all selects high. This lasts until an edge at which the acknowledge is high; the request may be raised again at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| paddr_i | input | 4 | Physical address bits 24..21 |
| as_n_i | input | 1 | Qualifying address strobe, active low |
| byp_ack_n_i | input | 1 | Bypass acknowledge from the arbiter, active low |
| byp_req_n_o | output | 1 | Composite bypass request to the arbiter, active low |
| slot_sel_n_o | output | 16 | Per-slot connector selects, active low |

## Verification
A new strobe and a still-held grant can land in the same cycle. When that happens, the lockout stage and the request generator both act on that edge. The bench provokes this as follows. It completes a granted transfer, then releases the strobe and drops it again while it keeps the acknowledge low. It then checks three things: the request stays high over several edges, every select stays high, and the request reappears exactly one edge after the acknowledge is released.

// File: rtl/slotdec_pkg.sv
package slotdec_pkg;

  // A code is live when it is nonzero, fitted, and below the reserved range.
  function automatic logic slot_is_live(input int unsigned code,
                                        input int unsigned populated,
                                        input int unsigned first_rsv);
    return (code != 0) && (code <= populated) && (code < first_rsv);
  endfunction

  // Lockout: cleared by a released acknowledge, set by a strobe start under grant.
  function automatic logic lock_next(input logic lock_q,
                                     input logic ack_n,
                                     input logic strobe_fall);
    return ack_n ? 1'b0 : (lock_q | strobe_fall);
  endfunction

endpackage

// File: rtl/byp_addr_capture.sv
module byp_addr_capture #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ack_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (ack_n) q <= d;
  end

  // Held while the arbiter grants
  assert_latch_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ack_n)) |-> $stable(q));

  // Follows while the arbiter is idle
  assert_latch_follow_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ack_n)) |-> (q == $past(d)));

endmodule

// File: rtl/slot_field_decode.sv
module slot_field_decode #(
  parameter int FW        = 4,
  parameter int POPULATED = 12,
  parameter int FIRST_RSV = 13
) (
  input  logic [FW-1:0]       code,
  output logic [(1<<FW)-1:0]  hit,
  output logic                live
);
  import slotdec_pkg::*;

  localparam int SLOTS = 1 << FW;

  generate
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      localparam logic LIVE_I = slot_is_live(i, POPULATED, FIRST_RSV);
      assign hit[i] = LIVE_I && (code == FW'(i));
    end
  endgenerate

  assign live = |hit;

endmodule

// File: rtl/byp_handshake.sv
module byp_handshake (
  input  logic clk,
  input  logic rst,
  input  logic as_n,
  input  logic ack_n,
  input  logic live,
  output logic req_n,
  output logic grant,
  output logic lock
);
  import slotdec_pkg::*;

  logic strb_prev_n;
  logic strobe_fall;
  logic lock_q;
  logic lock_d;
  logic req_n_q;
  logic req_on_d;

  assign strobe_fall = strb_prev_n & ~as_n;
  assign lock_d      = lock_next(lock_q, ack_n, strobe_fall);
  assign req_on_d    = ~as_n & live & ~lock_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      strb_prev_n <= 1'b1;
      lock_q      <= 1'b0;
      req_n_q     <= 1'b1;
    end else begin
      strb_prev_n <= as_n;
      lock_q      <= lock_d;
      req_n_q     <= ~req_on_d;
    end
  end

  assign req_n = req_n_q;
  assign lock  = lock_q;
  assign grant = ~ack_n & ~req_n_q & ~lock_q;

  assert_req_release_R9: assert property (@(posedge clk) disable iff (rst)
    $past(as_n) |-> req_n);

  assert_lock_blocks_R10: assert property (@(posedge clk) disable iff (rst)
    lock_q |-> (req_n && !grant));

  assert_lock_clears_R10: assert property (@(posedge clk) disable iff (rst)
    $past(ack_n) |-> !lock_q);

endmodule

// File: rtl/slot_select_decoder.sv
module slot_select_decoder #(
  parameter int FIELD_LSB = 21,
  parameter int FIELD_MSB = 24,
  parameter int POPULATED = 12,
  parameter int FIRST_RSV = 13
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic [FIELD_MSB:FIELD_LSB]                paddr_i,
  input  logic                                      as_n_i,
  input  logic                                      byp_ack_n_i,
  output logic                                      byp_req_n_o,
  output logic [(1<<(FIELD_MSB-FIELD_LSB+1))-1:0]   slot_sel_n_o
);

  localparam int FW    = FIELD_MSB - FIELD_LSB + 1;
  localparam int SLOTS = 1 << FW;

  logic [FW-1:0]    code_q;
  logic [SLOTS-1:0] hit;
  logic             live;
  logic             grant;
  logic             lock;

  byp_addr_capture #(.W(FW)) u_cap (
    .clk   (clk),
    .rst   (rst),
    .ack_n (byp_ack_n_i),
    .d     (paddr_i),
    .q     (code_q)
  );

  slot_field_decode #(.FW(FW), .POPULATED(POPULATED), .FIRST_RSV(FIRST_RSV)) u_dec (
    .code (code_q),
    .hit  (hit),
    .live (live)
  );

  byp_handshake u_hs (
    .clk   (clk),
    .rst   (rst),
    .as_n  (as_n_i),
    .ack_n (byp_ack_n_i),
    .live  (live),
    .req_n (byp_req_n_o),
    .grant (grant),
    .lock  (lock)
  );

  assign slot_sel_n_o = ~(hit & {SLOTS{grant}});

  assert_one_line_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~slot_sel_n_o));

  assert_reset_quiet_R2: assert property (@(posedge clk)
    $past(rst) |-> (byp_req_n_o && (&slot_sel_n_o)));

  assert_idle_code_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(code_q) == '0) |-> (byp_req_n_o && slot_sel_n_o[0]));

  assert_reserved_code_R4: assert property (@(posedge clk) disable iff (rst)
    (int'($past(code_q)) >= FIRST_RSV) |-> byp_req_n_o);

  assert_unfitted_code_R5: assert property (@(posedge clk) disable iff (rst)
    (int'($past(code_q)) > POPULATED) |-> byp_req_n_o);

  assert_sel_needs_ack_R7: assert property (@(posedge clk) disable iff (rst)
    (~slot_sel_n_o != '0) |-> !byp_ack_n_i);

  assert_lock_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    lock |-> (&slot_sel_n_o));

endmodule

// File: tb/sim_slot_select_decoder.sv
module sim_slot_select_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  pa  = 4'd0;
  logic        as_n = 1'b1;
  logic        ack_n = 1'b1;
  logic        req12_n, req4_n;
  logic [15:0] sel12_n, sel4_n;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  slot_select_decoder u0 (
    .clk(clk), .rst(rst), .paddr_i(pa), .as_n_i(as_n), .byp_ack_n_i(ack_n),
    .byp_req_n_o(req12_n), .slot_sel_n_o(sel12_n)
  );

  slot_select_decoder #(.POPULATED(4)) u1 (
    .clk(clk), .rst(rst), .paddr_i(pa), .as_n_i(as_n), .byp_ack_n_i(ack_n),
    .byp_req_n_o(req4_n), .slot_sel_n_o(sel4_n)
  );

  // {code[3:0], live in 12-slot build, live in 4-slot build}
  localparam logic [5:0] VEC [12] = '{
    6'b000000, 6'b000111, 6'b010011, 6'b010110,
    6'b011110, 6'b110010, 6'b110100, 6'b111000,
    6'b111100, 6'b001011, 6'b001111, 6'b101110
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] want_sel(input logic [3:0] code, input logic on);
    return on ? ~(16'd1 << code) : 16'hFFFF;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R6 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    ack_n = 1'b0;
    #1;
    chk("R2 reset req", {31'd0, req12_n}, 32'd1);
    chk("R2 reset sel", {16'd0, sel12_n}, 32'hFFFF);
    ack_n = 1'b1;
    rst = 1'b0;

    foreach (VEC[i]) begin
      logic [3:0] c;
      logic       e12, e4;
      c = VEC[i][5:2]; e12 = VEC[i][1]; e4 = VEC[i][0];
      @(negedge clk);
      pa = c; as_n = 1'b0; ack_n = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R6 req 12-slot", {31'd0, req12_n}, {31'd0, ~e12});
      chk("R5 req 4-slot",  {31'd0, req4_n},  {31'd0, ~e4});
      chk("R7 sel idle without ack", {16'd0, sel12_n}, 32'hFFFF);
      ack_n = 1'b0;
      #1;
      chk("R1 R3 R4 sel 12-slot", {16'd0, sel12_n}, {16'd0, want_sel(c, e12)});
      chk("R5 sel 4-slot",        {16'd0, sel4_n},  {16'd0, want_sel(c, e4)});
      pa = ~c;
      @(posedge clk);
      @(negedge clk);
      chk("R8 held during grant", {16'd0, sel12_n}, {16'd0, want_sel(c, e12)});
      as_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R9 req released", {31'd0, req12_n}, 32'd1);
      chk("R9 sel released", {16'd0, sel12_n}, 32'hFFFF);
      ack_n = 1'b1;
    end

    // R6: live code without strobe gives no request
    @(negedge clk);
    pa = 4'd5; as_n = 1'b1; ack_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R6 no strobe no req", {31'd0, req12_n}, 32'd1);

    // R7: acknowledge dropped and raised again within a grant
    as_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    ack_n = 1'b0;
    #1;
    chk("R7 sel with ack", {16'd0, sel12_n}, {16'd0, ~(16'd1 << 5)});
    @(negedge clk);
    ack_n = 1'b1;
    #1;
    chk("R7 sel gone with ack", {16'd0, sel12_n}, 32'hFFFF);

    // R10: new strobe under a held grant
    @(negedge clk);
    ack_n = 1'b0;
    @(negedge clk);
    as_n = 1'b1;
    @(negedge clk);
    as_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 lockout req", {31'd0, req12_n}, 32'd1);
    chk("R10 lockout sel", {16'd0, sel12_n}, 32'hFFFF);
    ack_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R10 req after release", {31'd0, req12_n}, 32'd0);

    // R2: reset in the middle of a grant
    ack_n = 1'b0;
    #1;
    chk("R2 grant before reset", {16'd0, sel12_n}, {16'd0, ~(16'd1 << 5)});
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R2 req after reset", {31'd0, req12_n}, 32'd1);
    chk("R2 sel after reset", {16'd0, sel12_n}, 32'hFFFF);
    rst = 1'b0;
    as_n = 1'b1;
    ack_n = 1'b1;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule